// File: doc/BRIEF.md
# RTC Calendar Register Bank

This block is the register front end of a real-time clock. It sits on a simple 32-bit, word-access bus and holds four things: a date word, a time word, a small control/status word that reports pending calendar updates, and a set of scratch words that software may use freely. A one-second tick from the clock domain moves the calendar forward. Seconds, minutes, hours, weekday, day, month and year offset all roll over here.

A write to the date word or to the time word stores the value. It also raises a sticky "update pending" flag for that word in the control word. A read of the control word returns both flags and then clears them. The control word itself cannot be written. A build-time parameter picks one of two address layouts. The layouts differ in where the calendar words sit, in the number and base address of the scratch words, and in the base year that the year offset counts from. Accesses to unmapped or misaligned addresses read as zero, change nothing, and raise an error response.

Top module: `rtc_regbank`

## Requirements
- R1: After reset every readable word (control, date, time, scratch) reads as zero and the error response is low.
- R2: A write to the date word stores all 32 bits and sets bit 7 of the control word (offset 0x00).
- R3: A write to the time word stores all 32 bits and sets bit 8 of the control word.
- R4: A read of the control word returns the pending flags in bits 7 (date) and 8 (time) with every other bit zero, and clears both flags after the read. A write to the control word has no effect.
- R5: With LAYOUT=0 the date word is at 0x04, the time word at 0x08, and four scratch words at 0x20, 0x24, 0x28 and 0x2C. With LAYOUT=1 the date word is at 0x10, the time word at 0x14, and eight scratch words at 0x100 through 0x11C, spaced by 4. Scratch words store and return all 32 bits.
- R6: An access whose address is not one of the mapped words, or whose low two address bits are not zero, reads as zero, leaves all state unchanged, and raises bus_err in the cycle after the access.
- R7: Read data and bus_err are registered: they appear in the cycle after the access, and both are zero in a cycle that follows no access.
- R8: The time word holds seconds in bits 7:0, minutes in bits 15:8, hours in bits 28:16 and weekday in bits 31:29, where 0 is Monday and 6 is Sunday. Each tick adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0.
- R9: The date word holds the day in bits 7:0, the month (1 to 12) in bits 15:8 and the year offset in bits 31:16. When the hours wrap, the weekday advances modulo 7. The day advances, and after the last day of the month it returns to 1 in the next month. The last day is 30 in April, June, September and November, 28 or 29 in February, and 31 in every other month. December rolls over to January of the next year offset.
- R10: A tick in the same cycle as a write to the date word or the time word is dropped, so the calendar holds exactly the written value afterwards.
- R11: February has 29 days when base year plus year offset is divisible by 4. The base year is 2010 for LAYOUT=0 and 1970 for LAYOUT=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the block window |
| bus_wdata | input | 32 | Write data |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_rdata | output | 32 | Read data, one cycle after a read |
| bus_err | output | 1 | Unmapped or misaligned access, one cycle after the access |

## Verification
The bench checks the flag protocol from several angles: read-to-clear, flags raised one at a time and together, and a second read returning zero. A design that cleared the flags before capturing them would return zero, and one that let the control word be written would show stray bits. It runs the calendar across the edges that catch wrong carries: 23:59:59 into midnight with the weekday wrapping from Sunday, February in leap and common years under both base years, a 30-day month, and New Year. A design with a wrong month table or base year would show the wrong day or month there. A tick that lands on a time write must leave the written value untouched, not one second ahead. Misaligned and unmapped writes are followed by reads of the words they might have hit, which exposes any decode that truncates low or high address bits.

// File: rtl/rtc_pkg.sv
// Shared definitions for the RTC calendar register bank: register select
// codes, per-layout address map and base year, and the month-length rule.
// Assumes byte addressing with 32-bit words.
package rtc_pkg;

    localparam int WORD_W        = 32;
    localparam int DATE_FLAG_BIT = 7;
    localparam int TIME_FLAG_BIT = 8;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_DATE = 3'd2,
        SEL_TIME = 3'd3,
        SEL_SCR  = 3'd4
    } reg_sel_e;

    function automatic int date_offset(input int layout);
        return (layout != 0) ? 'h10 : 'h04;
    endfunction

    function automatic int time_offset(input int layout);
        return (layout != 0) ? 'h14 : 'h08;
    endfunction

    function automatic int scr_base(input int layout);
        return (layout != 0) ? 'h100 : 'h20;
    endfunction

    function automatic int scr_count(input int layout);
        return (layout != 0) ? 8 : 4;
    endfunction

    function automatic int base_year(input int layout);
        return (layout != 0) ? 1970 : 2010;
    endfunction

    // Last valid day of a month; unknown month codes use 31.
    function automatic logic [7:0] month_days(input logic [7:0] month, input logic leap);
        case (month)
            8'd2:                       return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:    return 8'd30;
            default:                    return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
// Address decoder: maps a byte address to a register select and scratch
// index for the layout chosen at build time. Misaligned addresses and
// anything outside the mapped words decode to SEL_NONE. Purely combinational.
module rtc_addr_decode #(
    parameter int LAYOUT = 0,
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output rtc_pkg::reg_sel_e   sel,
    output logic [IDX_W-1:0]    scr_idx
);
    import rtc_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL   = '0;
    localparam logic [ADDR_W-1:0] A_DATE   = ADDR_W'(date_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] A_TIME   = ADDR_W'(time_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] A_SCR    = ADDR_W'(scr_base(LAYOUT));
    localparam logic [ADDR_W-1:0] SCR_SPAN = ADDR_W'(4 * scr_count(LAYOUT));

    logic [ADDR_W-1:0] rel;
    assign rel = addr - A_SCR;

    // Select the addressed register; the scratch range is checked by offset.
    always_comb begin
        sel     = SEL_NONE;
        scr_idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == A_CTRL)                       sel = SEL_CTRL;
            else if (addr == A_DATE)                  sel = SEL_DATE;
            else if (addr == A_TIME)                  sel = SEL_TIME;
            else if (addr >= A_SCR && rel < SCR_SPAN) begin
                sel     = SEL_SCR;
                scr_idx = rel[IDX_W+1:2];
            end
        end
    end

endmodule

// File: rtl/rtc_scratch.sv
// Scratch word array: NUM_SCR independent 32-bit registers, written one at
// a time, read through a combinational mux. Assumes rd_idx is in range.
module rtc_scratch #(
    parameter int NUM_SCR = 4,
    parameter int IDX_W   = 2,
    parameter int WORD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] words [NUM_SCR];

    for (genvar i = 0; i < NUM_SCR; i++) begin : g_word
        // Hold one scratch word; load on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)                               words[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))    words[i] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/rtc_calendar.sv
// Calendar state: date and time words with one-second advance. Bus writes
// take priority over a tick in the same cycle (the tick is lost). Assumes
// fields hold legal values; out-of-range fields wrap at the next tick.
module rtc_calendar #(
    parameter int WORD_W    = 32,
    parameter int BASE_YEAR = 2010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              date_we,
    input  logic              time_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              tick,
    output logic [WORD_W-1:0] date_q,
    output logic [WORD_W-1:0] time_q
);
    import rtc_pkg::*;

    localparam logic [1:0] BASE_MOD4 = 2'(BASE_YEAR % 4);

    logic [7:0]  sec, mins, day, mon, mlen;
    logic [12:0] hr;
    logic [2:0]  wday;
    logic [15:0] yr;
    logic        leap, sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;
    logic [WORD_W-1:0] date_nx, time_nx;

    assign sec  = time_q[7:0];
    assign mins = time_q[15:8];
    assign hr   = time_q[28:16];
    assign wday = time_q[31:29];
    assign day  = date_q[7:0];
    assign mon  = date_q[15:8];
    assign yr   = date_q[31:16];

    assign leap = (yr[1:0] + BASE_MOD4) == 2'b00;
    assign mlen = month_days(mon, leap);

    assign sec_wrap = sec >= 8'd59;
    assign min_wrap = sec_wrap && mins >= 8'd59;
    assign hr_wrap  = min_wrap && hr >= 13'd23;
    assign day_wrap = hr_wrap && day >= mlen;
    assign mon_wrap = day_wrap && mon >= 8'd12;

    // Build the next-second date and time words from the carry chain.
    always_comb begin
        time_nx[7:0]   = sec_wrap ? 8'd0 : sec + 8'd1;
        time_nx[15:8]  = !sec_wrap ? mins : (min_wrap ? 8'd0 : mins + 8'd1);
        time_nx[28:16] = !min_wrap ? hr : (hr_wrap ? 13'd0 : hr + 13'd1);
        time_nx[31:29] = !hr_wrap ? wday : ((wday >= 3'd6) ? 3'd0 : wday + 3'd1);
        date_nx[7:0]   = !hr_wrap ? day : (day_wrap ? 8'd1 : day + 8'd1);
        date_nx[15:8]  = !day_wrap ? mon : (mon_wrap ? 8'd1 : mon + 8'd1);
        date_nx[31:16] = mon_wrap ? yr + 16'd1 : yr;
    end

    // Update calendar: write first, else tick advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_q <= '0;
            time_q <= '0;
        end else if (date_we) begin
            date_q <= wdata;
        end else if (time_we) begin
            time_q <= wdata;
        end else if (tick) begin
            date_q <= date_nx;
            time_q <= time_nx;
        end
    end

endmodule

// File: rtl/rtc_regbank.sv
// RTC calendar register bank top. Decodes single-cycle bus accesses,
// keeps the sticky date/time pending flags (cleared by a control read),
// and returns registered read data and error one cycle after each access.
// Assumes bus_valid is a one-cycle request with no back-pressure.
module rtc_regbank #(
    parameter int LAYOUT = 0,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              sec_tick,
    output logic [31:0]       bus_rdata,
    output logic              bus_err
);
    import rtc_pkg::*;

    localparam int NUM_SCR   = scr_count(LAYOUT);
    localparam int IDX_W     = $clog2(NUM_SCR);
    localparam int BASE_YEAR = base_year(LAYOUT);

    reg_sel_e          sel;
    logic [IDX_W-1:0]  scr_idx;
    logic              rd_en, wr_en;
    logic              date_pend, time_pend;
    logic [WORD_W-1:0] date_word, time_word, scr_word, ctrl_word, rd_val;

    assign rd_en = bus_valid && !bus_write;
    assign wr_en = bus_valid && bus_write;

    rtc_addr_decode #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr    (bus_addr),
        .sel     (sel),
        .scr_idx (scr_idx)
    );

    rtc_calendar #(.WORD_W(WORD_W), .BASE_YEAR(BASE_YEAR)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .date_we (wr_en && sel == SEL_DATE),
        .time_we (wr_en && sel == SEL_TIME),
        .wdata   (bus_wdata),
        .tick    (sec_tick),
        .date_q  (date_word),
        .time_q  (time_word)
    );

    rtc_scratch #(.NUM_SCR(NUM_SCR), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && sel == SEL_SCR),
        .wr_idx  (scr_idx),
        .wr_data (bus_wdata),
        .rd_idx  (scr_idx),
        .rd_data (scr_word)
    );

    // Sticky pending flags: set by calendar writes, cleared by a control read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_pend <= 1'b0;
            time_pend <= 1'b0;
        end else if (rd_en && sel == SEL_CTRL) begin
            date_pend <= 1'b0;
            time_pend <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_DATE) date_pend <= 1'b1;
            if (sel == SEL_TIME) time_pend <= 1'b1;
        end
    end

    // Assemble the control word from the two flags.
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[DATE_FLAG_BIT] = date_pend;
        ctrl_word[TIME_FLAG_BIT] = time_pend;
    end

    // Pick the read value for the selected register.
    always_comb begin
        case (sel)
            SEL_CTRL: rd_val = ctrl_word;
            SEL_DATE: rd_val = date_word;
            SEL_TIME: rd_val = time_word;
            SEL_SCR:  rd_val = scr_word;
            default:  rd_val = '0;
        endcase
    end

    // Register the response; zero when there was no access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_en ? rd_val : '0;
            bus_err   <= bus_valid && sel == SEL_NONE;
        end
    end

endmodule

// File: rtl/rtc_regbank_chk.sv
// Property checker for rtc_regbank, attached by bind. Watches the bus,
// the tick, the responses and the internal flag and time state.
module rtc_regbank_chk #(
    parameter int LAYOUT = 0,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              sec_tick,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic              date_pend,
    input logic              time_pend,
    input logic [31:0]       time_word
);
    import rtc_pkg::*;

    localparam logic [ADDR_W-1:0] C_DATE = ADDR_W'(date_offset(LAYOUT));
    localparam logic [ADDR_W-1:0] C_TIME = ADDR_W'(time_offset(LAYOUT));

    p_date_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == C_DATE) |=> date_pend);

    p_time_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == C_TIME) |=> time_pend);

    p_ctrl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == '0) |=> (!date_pend && !time_pend));

    p_ctrl_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == '0)
        |=> bus_rdata == {23'd0, $past(time_pend), $past(date_pend), 7'd0});

    p_misalign_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[1:0] != 2'b00) |=> (bus_err && bus_rdata == '0));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (bus_rdata == '0 && !bus_err));

    p_sec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !bus_valid && time_word[7:0] == 8'd59) |=> time_word[7:0] == 8'd0);

    p_tick_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == C_TIME) |=> time_word == $past(bus_wdata));

endmodule

bind rtc_regbank rtc_regbank_chk #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sec_tick  (sec_tick),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .date_pend (date_pend),
    .time_pend (time_pend),
    .time_word (time_word)
);

// File: tb/rtc_regbank_bench.sv
// Bench: one instance per layout, a reference model in bench functions,
// directed corner cases, then seeded random traffic.
module rtc_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v  [2];
    logic        w  [2];
    logic [9:0]  a  [2];
    logic [31:0] wd [2];
    logic        tk [2];
    logic [31:0] rd [2];
    logic        er [2];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_date [2];
    logic [31:0] m_time [2];
    logic        m_dp   [2];
    logic        m_tp   [2];
    logic [31:0] m_scr  [2][8];

    always #5 clk = ~clk;

    rtc_regbank #(.LAYOUT(0), .ADDR_W(10)) u_rtc_regbank (
        .clk(clk), .rst_n(rst_n), .bus_valid(v[0]), .bus_write(w[0]),
        .bus_addr(a[0]), .bus_wdata(wd[0]), .sec_tick(tk[0]),
        .bus_rdata(rd[0]), .bus_err(er[0]));

    rtc_regbank #(.LAYOUT(1), .ADDR_W(10)) u_rtc_regbank_b (
        .clk(clk), .rst_n(rst_n), .bus_valid(v[1]), .bus_write(w[1]),
        .bus_addr(a[1]), .bus_wdata(wd[1]), .sec_tick(tk[1]),
        .bus_rdata(rd[1]), .bus_err(er[1]));

    function automatic int f_date(int l); return (l != 0) ? 'h10 : 'h04; endfunction
    function automatic int f_time(int l); return (l != 0) ? 'h14 : 'h08; endfunction
    function automatic int f_scr(int l, int i); return ((l != 0) ? 'h100 : 'h20) + 4 * i; endfunction
    function automatic int f_nscr(int l); return (l != 0) ? 8 : 4; endfunction
    function automatic int f_base(int l); return (l != 0) ? 1970 : 2010; endfunction

    function automatic int f_scr_idx(int l, int addr);
        for (int i = 0; i < f_nscr(l); i++)
            if (addr == f_scr(l, i)) return i;
        return -1;
    endfunction

    function automatic bit f_mapped(int l, int addr);
        return addr == 0 || addr == f_date(l) || addr == f_time(l) || f_scr_idx(l, addr) >= 0;
    endfunction

    function automatic int f_mdays(int mo, int year);
        if (mo == 2) return (year % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] f_mk_time(int wdy, int h, int mi, int s);
        return {3'(wdy), 13'(h), 8'(mi), 8'(s)};
    endfunction

    function automatic logic [31:0] f_mk_date(int yr, int mo, int dy);
        return {16'(yr), 8'(mo), 8'(dy)};
    endfunction

    // Reference one-second advance for legal field values.
    task automatic m_advance(int l);
        int s, mi, h, wdy, dy, mo, yr;
        s = int'(m_time[l][7:0]); mi = int'(m_time[l][15:8]);
        h = int'(m_time[l][28:16]); wdy = int'(m_time[l][31:29]);
        dy = int'(m_date[l][7:0]); mo = int'(m_date[l][15:8]); yr = int'(m_date[l][31:16]);
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h++;
                if (h == 24) begin
                    h = 0; wdy = (wdy + 1) % 7; dy++;
                    if (dy > f_mdays(mo, f_base(l) + yr)) begin
                        dy = 1; mo++;
                        if (mo == 13) begin mo = 1; yr++; end
                    end
                end
            end
        end
        m_time[l] = f_mk_time(wdy, h, mi, s);
        m_date[l] = f_mk_date(yr, mo, dy);
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(int l, int addr, logic [31:0] d, string req);
        int idx;
        @(negedge clk);
        v[l] = 1'b1; w[l] = 1'b1; a[l] = 10'(addr); wd[l] = d;
        @(negedge clk);
        v[l] = 1'b0; w[l] = 1'b0;
        check(er[l] == !f_mapped(l, addr), req, 32'(er[l]), 32'(!f_mapped(l, addr)));
        idx = f_scr_idx(l, addr);
        if (addr == f_date(l)) begin m_date[l] = d; m_dp[l] = 1'b1; end
        else if (addr == f_time(l)) begin m_time[l] = d; m_tp[l] = 1'b1; end
        else if (idx >= 0) m_scr[l][idx] = d;
    endtask

    task automatic bus_read(int l, int addr, string req);
        logic [31:0] exp;
        int idx;
        @(negedge clk);
        v[l] = 1'b1; w[l] = 1'b0; a[l] = 10'(addr);
        @(negedge clk);
        v[l] = 1'b0;
        idx = f_scr_idx(l, addr);
        exp = '0;
        if (addr == 0) begin
            exp = {23'd0, m_tp[l], m_dp[l], 7'd0};
            m_tp[l] = 1'b0; m_dp[l] = 1'b0;
        end
        else if (addr == f_date(l)) exp = m_date[l];
        else if (addr == f_time(l)) exp = m_time[l];
        else if (idx >= 0) exp = m_scr[l][idx];
        check(rd[l] == exp, req, rd[l], exp);
        check(er[l] == !f_mapped(l, addr), {req, " err"}, 32'(er[l]), 32'(!f_mapped(l, addr)));
    endtask

    task automatic do_tick(int l);
        @(negedge clk);
        tk[l] = 1'b1;
        @(negedge clk);
        tk[l] = 1'b0;
        m_advance(l);
    endtask

    // Set a calendar point, tick once, and compare both words.
    task automatic roll(int l, logic [31:0] d, logic [31:0] t,
                        logic [31:0] exp_d, logic [31:0] exp_t, string req);
        bus_write(l, f_date(l), d, req);
        bus_write(l, f_time(l), t, req);
        do_tick(l);
        check(m_date[l] == exp_d && m_time[l] == exp_t, {req, " model"}, m_date[l], exp_d);
        bus_read(l, f_date(l), req);
        bus_read(l, f_time(l), req);
        bus_read(l, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int l = 0; l < 2; l++) begin
            v[l] = 0; w[l] = 0; a[l] = '0; wd[l] = '0; tk[l] = 0;
            m_date[l] = '0; m_time[l] = '0; m_dp[l] = 0; m_tp[l] = 0;
            for (int i = 0; i < 8; i++) m_scr[l][i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int l = 0; l < 2; l++) begin
            // R1: reset state of every word
            bus_read(l, 0, "R1");
            bus_read(l, f_date(l), "R1");
            bus_read(l, f_time(l), "R1");
            for (int i = 0; i < f_nscr(l); i++) bus_read(l, f_scr(l, i), "R1");

            // R2 / R3 / R4: flags one at a time, together, then cleared
            bus_write(l, f_date(l), 32'h0005_0A0F, "R2");
            bus_read(l, 0, "R2");
            bus_read(l, 0, "R4");
            bus_write(l, f_time(l), f_mk_time(2, 10, 20, 30), "R3");
            bus_read(l, 0, "R3");
            bus_write(l, f_date(l), 32'h0001_0101, "R2");
            bus_write(l, f_time(l), f_mk_time(0, 1, 2, 3), "R3");
            bus_read(l, 0, "R4");
            bus_read(l, 0, "R4");
            bus_write(l, 0, 32'hFFFF_FFFF, "R4");
            bus_read(l, 0, "R4");

            // R5: scratch words store full 32 bits at the layout's addresses
            for (int i = 0; i < f_nscr(l); i++)
                bus_write(l, f_scr(l, i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101), "R5");
            for (int i = 0; i < f_nscr(l); i++) bus_read(l, f_scr(l, i), "R5");
            bus_read(l, f_date(l), "R5");

            // R6: misaligned and unmapped writes leave neighbours alone
            bus_write(l, f_scr(l, 1) + 2, 32'hDEAD_BEEF, "R6");
            bus_write(l, f_scr(l, f_nscr(l)), 32'hDEAD_BEEF, "R6");
            bus_write(l, f_date(l) + 1, 32'hDEAD_BEEF, "R6");
            bus_write(l, 'h3FC, 32'hDEAD_BEEF, "R6");
            bus_read(l, f_scr(l, 1), "R6");
            bus_read(l, f_scr(l, f_nscr(l) - 1), "R6");
            bus_read(l, f_date(l), "R6");
            bus_read(l, f_scr(l, 1) + 2, "R6");
            bus_read(l, 'h3FC, "R6");
            bus_read(l, 0, "R6");

            // R7: response is zero in the cycle after an idle cycle
            @(negedge clk);
            check(rd[l] == '0 && er[l] == 1'b0, "R7", rd[l], 32'd0);
        end

        // R8: seconds and minutes carry
        roll(0, f_mk_date(3, 5, 10), f_mk_time(1, 4, 7, 59),
             f_mk_date(3, 5, 10), f_mk_time(1, 4, 8, 0), "R8");
        roll(1, f_mk_date(3, 5, 10), f_mk_time(1, 4, 59, 59),
             f_mk_date(3, 5, 10), f_mk_time(1, 5, 0, 0), "R8");
        // R9: midnight with Sunday wrap, April end, New Year
        roll(0, f_mk_date(4, 4, 30), f_mk_time(6, 23, 59, 59),
             f_mk_date(4, 5, 1), f_mk_time(0, 0, 0, 0), "R9");
        roll(1, f_mk_date(0, 12, 31), f_mk_time(3, 23, 59, 59),
             f_mk_date(1, 1, 1), f_mk_time(4, 0, 0, 0), "R9");
        roll(0, f_mk_date(7, 1, 15), f_mk_time(2, 23, 59, 59),
             f_mk_date(7, 1, 16), f_mk_time(3, 0, 0, 0), "R9");
        // R11: leap rules per base year (2012 and 1972 leap; 2010 and 1970 not)
        roll(0, f_mk_date(2, 2, 28), f_mk_time(5, 23, 59, 59),
             f_mk_date(2, 2, 29), f_mk_time(6, 0, 0, 0), "R11");
        roll(0, f_mk_date(2, 2, 29), f_mk_time(5, 23, 59, 59),
             f_mk_date(2, 3, 1), f_mk_time(6, 0, 0, 0), "R11");
        roll(0, f_mk_date(0, 2, 28), f_mk_time(5, 23, 59, 59),
             f_mk_date(0, 3, 1), f_mk_time(6, 0, 0, 0), "R11");
        roll(1, f_mk_date(2, 2, 28), f_mk_time(0, 23, 59, 59),
             f_mk_date(2, 2, 29), f_mk_time(1, 0, 0, 0), "R11");
        roll(1, f_mk_date(0, 2, 28), f_mk_time(0, 23, 59, 59),
             f_mk_date(0, 3, 1), f_mk_time(1, 0, 0, 0), "R11");

        // R10: tick in the same cycle as a time write, then a date write
        for (int l = 0; l < 2; l++) begin
            @(negedge clk);
            v[l] = 1; w[l] = 1; a[l] = 10'(f_time(l)); wd[l] = f_mk_time(2, 12, 30, 59); tk[l] = 1;
            @(negedge clk);
            v[l] = 0; w[l] = 0; tk[l] = 0;
            m_time[l] = f_mk_time(2, 12, 30, 59); m_tp[l] = 1;
            bus_read(l, f_time(l), "R10");
            @(negedge clk);
            v[l] = 1; w[l] = 1; a[l] = 10'(f_date(l)); wd[l] = f_mk_date(9, 9, 9); tk[l] = 1;
            @(negedge clk);
            v[l] = 0; w[l] = 0; tk[l] = 0;
            m_date[l] = f_mk_date(9, 9, 9); m_dp[l] = 1;
            bus_read(l, f_date(l), "R10");
            bus_read(l, f_time(l), "R10");
            bus_read(l, 0, "R10");
        end

        // Random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int l, op, addr;
            l = int'($urandom % 2);
            op = int'($urandom % 8);
            case ($urandom % 4)
                0: addr = 0;
                1: addr = f_date(l);
                2: addr = f_time(l);
                default: addr = (($urandom % 2) != 0) ? f_scr(l, int'($urandom % 8))
                                                       : int'($urandom % 1024);
            endcase
            if (op < 3) do_tick(l);
            else if (op < 5) bus_read(l, addr, "R5");
            else if (addr == f_date(l))
                bus_write(l, addr, f_mk_date(int'($urandom % 100), 1 + int'($urandom % 12),
                                             1 + int'($urandom % 28)), "R2");
            else if (addr == f_time(l))
                bus_write(l, addr, f_mk_time(int'($urandom % 7), int'($urandom % 24),
                                             int'($urandom % 60), 55 + int'($urandom % 5)), "R3");
            else bus_write(l, addr, $urandom, "R6");
        end
        for (int l = 0; l < 2; l++) begin
            bus_read(l, f_date(l), "R9");
            bus_read(l, f_time(l), "R8");
            bus_read(l, 0, "R4");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule